// File: doc/BRIEF.md
# Completion Packet Receiver with Poll Timeout

After a configuration request has gone out, this block waits on a 32-bit receive word stream for the single completion packet that answers it. Words carry a start-of-packet and an end-of-packet flag. The block discards traffic until a start-flagged word arrives. It then stores the packet into a small four-word buffer and evaluates the header when the end flag is seen. The second stored word holds a 3-bit completion status and a 12-bit byte count.

For a read, a failing completion status turns into an all-ones result, which still counts as a normal completion. A successful status returns the fourth stored word, but only when the byte count says exactly four bytes and enough words arrived. For a write, the block only signals that the completion came back. If the end of packet does not arrive within a bounded number of polling attempts, the block finishes with an error flag raised.

A requester pulses `start_i` together with the read/write selector. It then waits for the one-cycle `done_o` pulse and reads `data_o` and `err_o`.

Top module: `cpl_rx_collector`

## Requirements
- R1: While `rst_n` is low and after its release, `done_o` and `err_o` are 0 and `data_o` is 0.
- R2: Words presented while no request is pending, and words without the start flag before the packet begins, are not stored and produce no `done_o`.
- R3: For a read, if bits [15:13] of the second stored word are nonzero, `data_o` becomes 32'hFFFFFFFF with `err_o` low.
- R4: For a read with a zero status, a byte count (bits [11:0] of the second stored word) equal to 4, and at least three words stored, `data_o` becomes the fourth stored word. A slot that received no word reads as zero, because every slot is cleared when a request is accepted.
- R5: For a read with a zero status whose byte count differs from 4, or with fewer than three words stored, `done_o` still pulses with `err_o` low, and `data_o` keeps its previous value. `data_o` never changes except in a cycle where `done_o` is high.
- R6: For a write, `done_o` pulses with `err_o` low, and `data_o` keeps its previous value whatever the status.
- R7: At most four words of a packet are stored. Words after the fourth, up to and including the end-flagged word, are dropped and do not alter the result.
- R8: If no end-flagged word has been stored after POLL_LIMIT polling attempts of POLL_INTERVAL cycles each, `done_o` pulses exactly POLL_LIMIT×POLL_INTERVAL rising edges after the edge that accepted the request. `err_o` rises with it and stays high until the next request is accepted. `data_o` is unchanged. An end-flagged word stored on the expiry edge wins over the timeout.
- R9: `done_o` is a one-cycle pulse given once per accepted request. A `start_i` pulse while a request is pending is ignored.
- R10: `done_o` is high during the cycle that follows the second rising edge counted from (and including) the edge that samples the end-flagged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request issued; accepted only when idle |
| is_read_i | input | 1 | 1 = read completion expected, 0 = write; sampled with start_i |
| rx_valid_i | input | 1 | Receive word present this cycle |
| rx_word_i | input | WORD_W | Receive word |
| rx_sop_i | input | 1 | Word is the first of a packet |
| rx_eop_i | input | 1 | Word is the last of a packet |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | WORD_W | Result register |
| err_o | output | 1 | Timeout error, held until the next accepted request |

## Verification
The embedded properties assume that `start_i` may arrive in any state, and that the receive flags matter only when `rx_valid_i` is high. They also assume the buffer depth is at least four and the polling limit is at least one. The stimulus changes every input at the falling clock edge and holds each word for exactly one cycle. It issues requests only through the start pulse, and it deliberately repeats that pulse while a request is pending to cover R9. Idle-time and pre-start traffic, overlong packets and short packets are all driven. The timeout case uses a reduced polling limit so that the exact expiry edge can be counted.

// File: rtl/cplrx_pkg.sv
package cplrx_pkg;
  // Field layout of the second stored word (decoded by the evaluator)
  localparam int STAT_LSB   = 13;
  localparam int STAT_W     = 3;
  localparam int BCNT_W     = 12;
  localparam int BCNT_FULL  = 4;
  // Buffer slot roles
  localparam int INFO_SLOT  = 1;
  localparam int DATA_SLOT  = 3;
  localparam int MIN_WORDS  = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/cplrx_poll_timer.sv
module cplrx_poll_timer #(
  parameter int INTERVAL = 1,
  parameter int LIMIT    = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int AW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cyc_q, cyc_n;
  logic [AW-1:0] att_q, att_n;
  logic          tick;
  logic          cnt_en;

  assign tick     = run_i && (cyc_q == CW'(INTERVAL - 1));
  assign expire_o = tick && (att_q == AW'(LIMIT - 1));
  assign cnt_en   = clear_i || run_i;

  always_comb begin
    cyc_n = cyc_q;
    att_n = att_q;
    if (clear_i) begin
      cyc_n = '0;
      att_n = '0;
    end else if (run_i) begin
      if (tick) begin
        cyc_n = '0;
        if (!expire_o) att_n = att_q + AW'(1);
      end else begin
        cyc_n = cyc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      att_q <= '0;
    end else if (cnt_en) begin
      cyc_q <= cyc_n;
      att_q <= att_n;
    end
  end

  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= AW'(LIMIT - 1)); // R8
endmodule

// File: rtl/cplrx_capture.sv
module cplrx_capture #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  logic                          arm_i,
  input  logic                          valid_i,
  input  logic [WORD_W-1:0]             word_i,
  input  logic                          sop_i,
  input  logic                          eop_i,
  output logic [DEPTH-1:0][WORD_W-1:0]  slot_o,
  output logic [CNTW-1:0]               cnt_o,
  output logic                          take_eop_o,
  output logic                          pkt_done_o
);
  logic [DEPTH-1:0][WORD_W-1:0] slot_q, slot_n;
  logic [CNTW-1:0]              cnt_q, cnt_n;
  logic                         inpkt_q, inpkt_n;
  logic                         done_q, done_n;
  logic                         take, room, reg_en;

  assign take       = arm_i && valid_i && (inpkt_q || sop_i);
  assign room       = cnt_q < CNTW'(DEPTH);
  assign take_eop_o = take && eop_i;
  assign reg_en     = clear_i || take || done_q;

  always_comb begin
    slot_n  = slot_q;
    cnt_n   = cnt_q;
    inpkt_n = inpkt_q;
    done_n  = 1'b0;
    if (clear_i) begin
      slot_n  = '0;
      cnt_n   = '0;
      inpkt_n = 1'b0;
    end else if (take) begin
      if (room) begin
        slot_n[cnt_q] = word_i;
        cnt_n         = cnt_q + CNTW'(1);
      end
      inpkt_n = !eop_i;
      done_n  = eop_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      cnt_q   <= '0;
      inpkt_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (reg_en) begin
      slot_q  <= slot_n;
      cnt_q   <= cnt_n;
      inpkt_q <= inpkt_n;
      done_q  <= done_n;
    end
  end

  assign slot_o     = slot_q;
  assign cnt_o      = cnt_q;
  assign pkt_done_o = done_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH)); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNTW'(DEPTH) && !clear_i) |=> $stable(slot_q)); // R7
  AST_UNARMED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !clear_i) |=> ($stable(cnt_q) && $stable(slot_q))); // R2
endmodule

// File: rtl/cplrx_eval.sv
module cplrx_eval
  import cplrx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] slot_i,
  input  logic [CNTW-1:0]              cnt_i,
  output logic                         status_bad_o,
  output logic                         data_ok_o
);
  logic [WORD_W-1:0] info;
  logic [STAT_W-1:0] status;
  logic [BCNT_W-1:0] bcount;

  always_comb begin
    info         = slot_i[INFO_SLOT];
    status       = info[STAT_LSB +: STAT_W];
    bcount       = info[BCNT_W-1:0];
    status_bad_o = status != '0;
    data_ok_o    = !status_bad_o
                   && (bcount == BCNT_W'(BCNT_FULL))
                   && (cnt_i >= CNTW'(MIN_WORDS));
  end
endmodule

// File: rtl/cpl_rx_collector.sv
module cpl_rx_collector
  import cplrx_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int BUF_WORDS     = 4,
  parameter int POLL_INTERVAL = 1,
  parameter int POLL_LIMIT    = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_read_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_sop_i,
  input  logic              rx_eop_i,
  output logic              done_o,
  output logic [WORD_W-1:0] data_o,
  output logic              err_o
);
  localparam int CNTW = $clog2(BUF_WORDS + 1);

  rx_state_e                       state_q, state_n;
  logic                            done_q, done_n;
  logic                            err_q, err_n;
  logic                            rd_q, rd_n;
  logic [WORD_W-1:0]               data_q, data_n;
  logic                            clear, arm, expire;
  logic [BUF_WORDS-1:0][WORD_W-1:0] slots;
  logic [CNTW-1:0]                 cnt;
  logic                            take_eop, pkt_done;
  logic                            status_bad, data_ok;

  assign arm = (state_q == ST_WAIT) && !pkt_done;

  cplrx_poll_timer #(
    .INTERVAL (POLL_INTERVAL),
    .LIMIT    (POLL_LIMIT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear),
    .run_i    (arm),
    .expire_o (expire)
  );

  cplrx_capture #(
    .WORD_W (WORD_W),
    .DEPTH  (BUF_WORDS)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .arm_i      (arm),
    .valid_i    (rx_valid_i),
    .word_i     (rx_word_i),
    .sop_i      (rx_sop_i),
    .eop_i      (rx_eop_i),
    .slot_o     (slots),
    .cnt_o      (cnt),
    .take_eop_o (take_eop),
    .pkt_done_o (pkt_done)
  );

  cplrx_eval #(
    .WORD_W (WORD_W),
    .DEPTH  (BUF_WORDS)
  ) u_eval (
    .slot_i       (slots),
    .cnt_i        (cnt),
    .status_bad_o (status_bad),
    .data_ok_o    (data_ok)
  );

  always_comb begin
    state_n = state_q;
    done_n  = 1'b0;
    err_n   = err_q;
    rd_n    = rd_q;
    data_n  = data_q;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_WAIT;
          clear   = 1'b1;
          err_n   = 1'b0;
          rd_n    = is_read_i;
        end
      end
      ST_WAIT: begin
        if (pkt_done) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          if (rd_q) begin
            if (status_bad)   data_n = '1;
            else if (data_ok) data_n = slots[DATA_SLOT];
          end
        end else if (expire && !take_eop) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          err_n   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      err_q   <= err_n;
      rd_q    <= rd_n;
      data_q  <= data_n;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign data_o = data_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_ERR_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o); // R8
  AST_DATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_o != $past(data_o)) |-> done_o); // R5
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !rd_q) |-> (data_o == $past(data_o))); // R6
  AST_TIMEOUT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (data_o == $past(data_o))); // R8
endmodule

// File: tb/cpl_rx_collector_test.sv
module cpl_rx_collector_test;
  localparam int LIM = 30;
  localparam int INT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        is_read_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [31:0] rx_word_i = '0;
  logic        rx_sop_i = 1'b0;
  logic        rx_eop_i = 1'b0;
  logic        done_o;
  logic [31:0] data_o;
  logic        err_o;

  always #2 clk = ~clk; // 250 MHz

  cpl_rx_collector #(
    .WORD_W (32), .BUF_WORDS (4), .POLL_INTERVAL (INT), .POLL_LIMIT (LIM)
  ) uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .is_read_i (is_read_i),
    .rx_valid_i (rx_valid_i), .rx_word_i (rx_word_i), .rx_sop_i (rx_sop_i),
    .rx_eop_i (rx_eop_i), .done_o (done_o), .data_o (data_o), .err_o (err_o)
  );

  typedef struct packed {
    logic [31:0] data;
    logic        err;
    logic [3:0]  req;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          errors = 0;
  int          dones  = 0;
  logic [31:0] model_data = '0;
  logic        prev_done = 1'b0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every completion pulse
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (done_o && prev_done)
        check(1'b0, "R9", "done wider than one cycle", 32'd1, 32'd0);
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(data_o == e.data, $sformatf("R%0d", e.req), "data_o", data_o, e.data);
          check(err_o == e.err, $sformatf("R%0d", e.req), "err_o",
                {31'd0, err_o}, {31'd0, e.err});
        end
      end
      prev_done = done_o;
    end
  end

  task automatic issue_start(input bit rd);
    @(negedge clk);
    start_i   = 1'b1;
    is_read_i = rd;
    @(posedge clk);
    #1;
    start_i   = 1'b0;
  endtask

  task automatic drive_word(input logic [31:0] w, input bit sop, input bit eop);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_word_i  = w;
    rx_sop_i   = sop;
    rx_eop_i   = eop;
  endtask

  task automatic idle_bus();
    @(negedge clk);
    rx_valid_i = 1'b0;
    rx_sop_i   = 1'b0;
    rx_eop_i   = 1'b0;
  endtask

  // Driver: computes the expected result, pushes it, then plays the packet
  task automatic do_txn(input bit rd, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2, input logic [31:0] w3,
                        input logic [31:0] w4, input logic [31:0] w5,
                        input int n, input int junk, input bit restart,
                        input logic [3:0] req);
    logic [31:0] pw[6];
    logic [31:0] info, d3;
    exp_t        e;
    int          k;
    int          stored;
    pw[0] = w0; pw[1] = w1; pw[2] = w2; pw[3] = w3; pw[4] = w4; pw[5] = w5;
    info   = (n > 1) ? w1 : 32'd0;
    d3     = (n > 3) ? w3 : 32'd0;      // unfilled slot reads zero (R4)
    stored = (n > 4) ? 4 : n;           // at most four stored (R7)
    if (rd) begin
      if (info[15:13] != 3'd0) model_data = 32'hFFFF_FFFF;
      else if (info[11:0] == 12'd4 && stored >= 3) model_data = d3;
    end
    e.data = model_data; e.err = 1'b0; e.req = req;
    exp_q.push_back(e);
    issue_start(rd);
    for (int j = 0; j < junk; j++) drive_word(32'hBAD0_0000 + j, 1'b0, (j == 0)); // R2
    if (restart) begin
      @(negedge clk);
      start_i = 1'b1; is_read_i = ~rd;   // ignored while pending (R9)
      rx_valid_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int j = 0; j < n; j++) drive_word(pw[j], (j == 0), (j == n - 1));
    @(posedge clk);
    #1;
    rx_valid_i = 1'b0; rx_sop_i = 1'b0; rx_eop_i = 1'b0;
    k = 1;
    while (!done_o && k < 20) begin
      @(posedge clk);
      #1;
      k++;
    end
    check(k == 2, "R10", "edges from end word to done", k, 32'd2);
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int k;
    repeat (3) @(posedge clk);
    #1;
    check(done_o == 1'b0, "R1", "done_o in reset", {31'd0, done_o}, 32'd0);
    check(err_o == 1'b0, "R1", "err_o in reset", {31'd0, err_o}, 32'd0);
    check(data_o == 32'd0, "R1", "data_o in reset", data_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(done_o == 1'b0 && err_o == 1'b0 && data_o == 32'd0, "R1",
          "outputs after release", data_o, 32'd0);

    // R2: complete packet while idle is ignored
    drive_word(32'h4A00_0001, 1'b1, 1'b0);
    drive_word(32'h0000_0004, 1'b0, 1'b0);
    drive_word(32'h0000_0000, 1'b0, 1'b0);
    drive_word(32'h7777_7777, 1'b0, 1'b1);
    idle_bus();
    repeat (4) @(posedge clk);
    #1;
    check(data_o == 32'd0 && dones == 0, "R2", "idle traffic", data_o, 32'd0);

    // R2 R4: junk before start flag, then good read
    do_txn(1'b1, 32'h4A00_0001, 32'h0000_0004, 32'h0001_0000, 32'hDEAD_BEEF,
           32'd0, 32'd0, 4, 2, 1'b0, 4'd4);
    // R3: nonzero status -> all ones
    do_txn(1'b1, 32'h4A00_0001, 32'h0000_6004, 32'h0, 32'h1111_2222,
           32'd0, 32'd0, 4, 0, 1'b0, 4'd3);
    // R5: byte count 8 -> hold
    do_txn(1'b1, 32'h4A00_0001, 32'h0000_0008, 32'h0, 32'h3333_4444,
           32'd0, 32'd0, 4, 0, 1'b0, 4'd5);
    // R4: three words only -> empty fourth slot reads zero
    do_txn(1'b1, 32'h4A00_0001, 32'h0000_0004, 32'h0, 32'h5555_6666,
           32'd0, 32'd0, 3, 1, 1'b0, 4'd4);
    // R7: six-word packet, extra words dropped
    do_txn(1'b1, 32'h4A00_0001, 32'h0000_0004, 32'h0, 32'h1234_5678,
           32'hAAAA_5555, 32'h5555_AAAA, 6, 0, 1'b0, 4'd7);
    // R6: write completion with failing status keeps data
    do_txn(1'b0, 32'h4A00_0001, 32'h0000_2004, 32'h0, 32'h9999_0000,
           32'd0, 32'd0, 4, 0, 1'b0, 4'd6);
    // R5: two words only -> hold
    do_txn(1'b1, 32'h4A00_0001, 32'h0000_0004, 32'h0, 32'h0,
           32'd0, 32'd0, 2, 0, 1'b0, 4'd5);
    // R9: second start while pending is ignored
    do_txn(1'b1, 32'h4A00_0001, 32'h0000_0004, 32'h0, 32'hCAFE_F00D,
           32'd0, 32'd0, 4, 1, 1'b1, 4'd9);

    // R8: timeout at exactly LIM*INT edges after acceptance
    begin
      exp_t e;
      e.data = model_data; e.err = 1'b1; e.req = 4'd8;
      exp_q.push_back(e);
    end
    issue_start(1'b1);
    k = 0;
    while (!done_o && k < LIM * INT + 10) begin
      @(posedge clk);
      #1;
      k++;
    end
    check(k == LIM * INT, "R8", "timeout edge count", k, LIM * INT);
    repeat (5) @(posedge clk);
    #1;
    check(err_o == 1'b1, "R8", "err held after timeout", {31'd0, err_o}, 32'd1);
    issue_start(1'b1);
    check(err_o == 1'b0, "R8", "err cleared by new request", {31'd0, err_o}, 32'd0);
    begin
      exp_t e;
      model_data = 32'h0BAD_F00D;
      e.data = model_data; e.err = 1'b0; e.req = 4'd4;
      exp_q.push_back(e);
    end
    drive_word(32'h4A00_0001, 1'b1, 1'b0);
    drive_word(32'h0000_0004, 1'b0, 1'b0);
    drive_word(32'h0000_0000, 1'b0, 1'b0);
    drive_word(32'h0BAD_F00D, 1'b0, 1'b1);
    idle_bus();
    repeat (6) @(posedge clk);
    #1;

    check(exp_q.size() == 0, "R9", "pending expected results", exp_q.size(), 32'd0);
    check(dones == 10, "R9", "done pulse count", dones, 32'd10);
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule